// File: doc/BRIEF.md
# Panel Row Strobe and Enable Pulse Generator

This block takes one 32-bit command from a row sequencer and turns it into the control waveform that a multiplexed LED matrix panel needs for one row and one bit plane. It places a row address on the address lines, waits a short settling phase with the display dark, raises a latch strobe for a fixed number of cycles so the panel transfers its shifted column data, and then lights the row by asserting output enable for a command-given number of cycles.

The command packs the row address in bits [4:0] and the enable length in bits [31:5]. The enable line is lit for exactly that length plus one cycle, so a length of zero still gives a one-cycle flash. A build parameter chooses whether the enable pin is active low (the usual panel convention) or active high. The sequencer sees `cmd_ready_o` and `idle_o` and may offer the next command as soon as the block reports idle.

Top module: `rowpulse_top`

## Requirements
- R1: After synchronous reset the block is idle: `idle_o`=1, `cmd_ready_o`=1, `lat_o`=0, `row_addr_o`=0 and the enable pin at its inactive level.
- R2: A command is taken at a rising edge where `cmd_valid_i` and `cmd_ready_o` are both 1; from the next cycle `row_addr_o` equals bits [4:0] of that command and `cmd_ready_o` and `idle_o` are 0.
- R3: The first 2 cycles after acceptance form the address phase: `lat_o`=0 and the enable pin inactive.
- R4: Directly after the address phase `lat_o` is 1 for exactly 8 consecutive cycles, with the enable pin inactive throughout.
- R5: Directly after the latch phase the enable pin is at its active level for exactly N+1 consecutive cycles, where N is bits [31:5] of the accepted command.
- R6: In the cycle after the last enable cycle the block is idle again (`idle_o`=1, `cmd_ready_o`=1) with the enable pin inactive and `lat_o`=0.
- R7: `row_addr_o` changes only in the cycle after a command is accepted and holds steady through the latch and enable phases.
- R8: A command offered while the block is busy has no effect on the address, the latch timing or the enable length of the command in progress.
- R9: With `OE_INVERT`=0 the enable pin is active at 0 and inactive at 1; with `OE_INVERT`=1 both levels are swapped and all timing is unchanged.
- R10: `lat_o` is never 1 while the enable pin is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_data_i | input | 32 | Command: [31:5] enable length, [4:0] row address |
| row_addr_o | output | 5 | Row address lines |
| lat_o | output | 1 | Latch strobe, active high |
| oe_pin_o | output | 1 | Output-enable pin, polarity set by OE_INVERT |
| idle_o | output | 1 | High when no command is in progress |

## Verification
The bench targets the enable length at its smallest value, where a design that counted N instead of N+1 would emit no flash at all, and at several other lengths where an off-by-one shows as a pulse one cycle short or long. It checks the exact cycle where the latch rises and the enable starts, which catches a wrong address-phase or latch-phase length, and checks that the latch and enable never overlap. A second command pushed in mid-operation would, in a design that ignored ready, corrupt the address or restart the timer. An inverted-polarity copy runs beside the default copy so that a swapped or missing level inversion shows as a mismatch on every cycle.

// File: rtl/rowpulse_pkg.sv
package rowpulse_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_LATCH  = 2'd2,
    PH_ENABLE = 2'd3
  } phase_e;

endpackage

// File: rtl/rowpulse_cmd_reg.sv
module rowpulse_cmd_reg #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 27,
  localparam int CMD_W = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      addr_q <= cmd[ADDR_W-1:0];
      cnt_q  <= cmd[CMD_W-1:ADDR_W];
    end
  end

endmodule

// File: rtl/rowpulse_timer.sv
module rowpulse_timer #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         at_zero
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - W'(1);
    end
  end

  assign at_zero = (remain_q == '0);

endmodule

// File: rtl/rowpulse_seq.sv
module rowpulse_seq
  import rowpulse_pkg::*;
#(
  parameter int CNT_W     = 27,
  parameter int ADDR_HOLD = 2,
  parameter int LAT_CYC   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             take,
  output logic             lat_q,
  output logic             idle_q,
  output logic             en_next
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(ADDR_HOLD - 1);
  localparam logic [CNT_W-1:0] LAT_LAST  = CNT_W'(LAT_CYC - 1);

  phase_e phase_q, phase_d;

  assign take = idle_q && cmd_valid;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          phase_d  = PH_ADDR;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LAST;
        end
      end
      PH_ADDR: begin
        if (tmr_zero) begin
          phase_d  = PH_LATCH;
          tmr_load = 1'b1;
          tmr_val  = LAT_LAST;
        end
      end
      PH_LATCH: begin
        if (tmr_zero) begin
          phase_d  = PH_ENABLE;
          tmr_load = 1'b1;
          tmr_val  = pulse_cnt;
        end
      end
      PH_ENABLE: begin
        if (tmr_zero) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign en_next = (phase_d == PH_ENABLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      lat_q   <= 1'b0;
      idle_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      lat_q   <= (phase_d == PH_LATCH);
      idle_q  <= (phase_d == PH_IDLE);
    end
  end

endmodule

// File: rtl/rowpulse_oe_drive.sv
module rowpulse_oe_drive #(
  parameter bit OE_INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en_next,
  output logic oe_pin
);

  generate
    if (OE_INVERT) begin : g_active_high
      always_ff @(posedge clk) begin
        if (rst) oe_pin <= 1'b0;
        else     oe_pin <= en_next;
      end
    end else begin : g_active_low
      always_ff @(posedge clk) begin
        if (rst) oe_pin <= 1'b1;
        else     oe_pin <= ~en_next;
      end
    end
  endgenerate

endmodule

// File: rtl/rowpulse_top.sv
module rowpulse_top #(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 27,
  parameter int ADDR_HOLD = 2,
  parameter int LAT_CYC   = 8,
  parameter bit OE_INVERT = 1'b0,
  localparam int CMD_W    = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              lat_o,
  output logic              oe_pin_o,
  output logic              idle_o
);

  logic             take;
  logic [CNT_W-1:0] cnt_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             en_next;
  logic             idle_q;

  rowpulse_cmd_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmd (
    .clk(clk), .rst(rst), .take(take), .cmd(cmd_data_i),
    .addr_q(row_addr_o), .cnt_q(cnt_q)
  );

  rowpulse_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .at_zero(tmr_zero)
  );

  rowpulse_seq #(.CNT_W(CNT_W), .ADDR_HOLD(ADDR_HOLD), .LAT_CYC(LAT_CYC)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid_i), .pulse_cnt(cnt_q),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .take(take), .lat_q(lat_o), .idle_q(idle_q), .en_next(en_next)
  );

  rowpulse_oe_drive #(.OE_INVERT(OE_INVERT)) u_oe (
    .clk(clk), .rst(rst), .en_next(en_next), .oe_pin(oe_pin_o)
  );

  assign idle_o      = idle_q;
  assign cmd_ready_o = idle_q;

endmodule

// File: rtl/rowpulse_chk.sv
module rowpulse_chk #(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 27,
  parameter int LAT_CYC   = 8,
  parameter bit OE_INVERT = 1'b0,
  localparam int CMD_W    = ADDR_W + CNT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [CMD_W-1:0]  cmd_data_i,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic              lat_o,
  input logic              oe_pin_o,
  input logic              idle_o
);

  logic             oe_on;
  logic             acc;
  logic [CNT_W:0]   oe_run;
  logic [CNT_W:0]   lat_run;
  logic [CNT_W-1:0] cnt_cap;

  assign oe_on = (oe_pin_o == OE_INVERT);
  assign acc   = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_run  <= '0;
      lat_run <= '0;
      cnt_cap <= '0;
    end else begin
      oe_run  <= oe_on ? oe_run + 1'b1 : '0;
      lat_run <= lat_o ? lat_run + 1'b1 : '0;
      if (acc) cnt_cap <= cmd_data_i[CMD_W-1:ADDR_W];
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc |=> (!cmd_ready_o && !idle_o)); // R2
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    acc |=> (row_addr_o == $past(cmd_data_i[ADDR_W-1:0]))); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(row_addr_o)); // R7
  AST_LAT_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(lat_o) |-> (lat_run == (CNT_W+1)'(LAT_CYC))); // R4
  AST_OE_LEN: assert property (@(posedge clk) disable iff (rst)
    (!oe_on && oe_run != '0) |-> (oe_run == {1'b0, cnt_cap} + 1'b1)); // R5
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> (!oe_on && !lat_o)); // R6
  AST_LAT_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lat_o && oe_on)); // R10

endmodule

bind rowpulse_top rowpulse_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LAT_CYC(LAT_CYC), .OE_INVERT(OE_INVERT)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_data_i(cmd_data_i), .row_addr_o(row_addr_o), .lat_o(lat_o),
  .oe_pin_o(oe_pin_o), .idle_o(idle_o)
);

// File: tb/rowpulse_top_tb_top.sv
`timescale 1ns/1ps
module rowpulse_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        ready_a, ready_b, lat_a, lat_b, oe_a, oe_b, idle_a, idle_b;
  logic [4:0]  addr_a, addr_b;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  rowpulse_top dut_i (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready_a),
    .cmd_data_i(cmd_data), .row_addr_o(addr_a), .lat_o(lat_a),
    .oe_pin_o(oe_a), .idle_o(idle_a)
  );

  rowpulse_top #(.OE_INVERT(1'b1)) dut_inv_i (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready_b),
    .cmd_data_i(cmd_data), .row_addr_o(addr_b), .lat_o(lat_b),
    .oe_pin_o(oe_b), .idle_o(idle_b)
  );

  // Each vector: {enable length N (27 bits), row address (5 bits)}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {27'd0,  5'd3},
    {27'd1,  5'd31},
    {27'd3,  5'd0},
    {27'd5,  5'd17},
    {27'd17, 5'd9},
    {27'd2,  5'd22}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_up();
    end
  end

  // Issue one command; optionally offer a second command while busy (R8).
  task automatic run_cmd(input logic [31:0] c, input bit poke);
    int n      = int'(c[31:5]);
    int last   = 12 + n;
    int first_lat = -1, lat_cnt = 0, first_oe = -1, oe_cnt = 0;
    bit addr_bad = 0, busy_bad = 0, inv_bad = 0, overlap = 0, addr_ph_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == 1) cmd_valid = 1'b0;
      if (poke && k == 4) begin cmd_valid = 1'b1; cmd_data = ~c; end
      if (poke && k == 9) cmd_valid = 1'b0;
      if (k < last) begin
        if (addr_a !== c[4:0]) addr_bad = 1;
        if (ready_a !== 1'b0 || idle_a !== 1'b0) busy_bad = 1;
        if (lat_a === 1'b1) begin
          if (first_lat < 0) first_lat = k;
          lat_cnt++;
        end
        if (oe_a === 1'b0) begin
          if (first_oe < 0) first_oe = k;
          oe_cnt++;
        end
        if (lat_a === 1'b1 && oe_a === 1'b0) overlap = 1;
        if (k <= 2 && (lat_a !== 1'b0 || oe_a !== 1'b1)) addr_ph_bad = 1;
      end
      if (oe_b !== ~oe_a || lat_b !== lat_a || addr_b !== addr_a || idle_b !== idle_a)
        inv_bad = 1;
    end
    check(!addr_bad, "R2/R7 address held", int'(addr_a), int'(c[4:0]));
    check(!busy_bad, "R2 busy while active", int'(ready_a), 0);
    check(!addr_ph_bad, "R3 address phase dark", int'(oe_a), 1);
    check(first_lat == 3 && lat_cnt == 8, "R4 latch start/len", first_lat*100 + lat_cnt, 308);
    check(first_oe == 11 && oe_cnt == n + 1, "R5 enable start/len",
          first_oe*100000 + oe_cnt, 11*100000 + n + 1);
    check(!overlap, "R10 latch/enable overlap", int'(overlap), 0);
    check(idle_a === 1'b1 && ready_a === 1'b1 && oe_a === 1'b1 && lat_a === 1'b0,
          "R6 idle after pulse", {idle_a, ready_a, oe_a, lat_a}, 4'b1110);
    check(!inv_bad, "R9 inverted polarity copy", int'(oe_b), int'(~oe_a));
    if (poke) check(addr_a === c[4:0], "R8 busy command ignored", int'(addr_a), int'(c[4:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idle_a === 1'b1 && ready_a === 1'b1 && lat_a === 1'b0 && oe_a === 1'b1
          && addr_a === 5'd0, "R1 reset state (in reset)",
          {idle_a, ready_a, lat_a, oe_a}, 4'b1101);
    rst = 1'b0;
    @(negedge clk);
    check(idle_a === 1'b1 && ready_a === 1'b1 && oe_a === 1'b1 && oe_b === 1'b0,
          "R1 R9 idle levels after reset", {idle_a, ready_a, oe_a, oe_b}, 4'b1110);

    for (int v = 0; v < NV; v++) run_cmd(VEC[v], 1'b0);

    // R8: a command offered mid-operation must not disturb the current one
    run_cmd({27'd4, 5'd12}, 1'b1);
    // the poked command was withdrawn before idle: block stays idle
    repeat (3) @(negedge clk);
    check(idle_a === 1'b1 && addr_a === 5'd12, "R8 withdrawn command not taken",
          int'(addr_a), 12);

    // Back-to-back after idle, smallest length again (R5)
    run_cmd({27'd0, 5'd30}, 1'b0);

    // Reset mid-operation returns to idle with enable dark (R1)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = {27'd50, 5'd7};
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(idle_a === 1'b1 && oe_a === 1'b1 && lat_a === 1'b0 && addr_a === 5'd0,
          "R1 reset during enable", {idle_a, oe_a, lat_a}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    finish_up();
  end

endmodule